// File: doc/BRIEF.md
# Self-Checking Lockstep Output Comparator

This block watches a dual-core lockstep pair in which a shadow core runs a fixed two cycles behind a primary core. It delays the primary output bus by two cycles and compares it with the shadow bus. Two identical combinational comparators do this on every cycle. Each output bit is assigned to one of up to 64 programmable slices, and each comparator produces a per-slice mismatch vector.

When both comparators see a mismatch, the cores have diverged, and a divergence alarm is raised. The alarm is steered to one of two lines by a disabled-mode input. When only one comparator sees a mismatch, the comparator itself is suspect. In that case a self-diagnostic engine snapshots both delayed buses and re-checks them one slice per cycle. It then reports either "comparator fault only" or "comparator fault plus core fault".

A fault-injection input inverts the result of one chosen slice in the main comparator, so the whole alarm path can be exercised in the field. Alarms and a 64-bit mask of offending slice IDs are sticky until cleared.

Top module: `lockstep_cmp`

## Requirements
- R1: The primary bus is delayed by exactly two clock cycles before comparison. A shadow bus equal to the primary bus of two cycles earlier raises no alarm. A shadow bus equal to the primary bus of one cycle earlier is treated as a mismatch whenever those values differ.
- R2: While `inj_en` is high, the main comparator's result for slice `inj_slice` is inverted. The second comparator and the diagnostic engine are not affected.
- R3: When both comparators report a mismatch on the same cycle, alarm bit 0 is set on the next edge if `cmp_disabled` is low, or alarm bit 1 if it is high. No diagnostic pass starts.
- R4: When exactly one comparator reports a mismatch and no diagnostic pass is running, the next edge does three things. It sets alarm bit 0 or bit 1 (chosen as in R3). It sets alarm bit 2. It starts a diagnostic pass on snapshots of the delayed primary bus and the shadow bus taken on that edge.
- R5: A diagnostic pass checks slices 0 to NUM_SLICES-1, one slice per cycle. Its result appears exactly NUM_SLICES edges after the starting edge, which is at most 64 cycles. Alarm bit 3 is set if no slice mismatched, and alarm bit 4 is set if any slice did.
- R6: While a pass is running, a disagreement between the comparators is ignored. It does not change alarms or the slice mask, and it does not shift the pass's result timing.
- R7: Bit i of the compared bus belongs to the slice whose 6-bit ID is held in `slice_map[6*i +: 6]`. Whenever a mismatch is recorded, every slice flagged by either comparator is set in `slice_hits`.
- R8: Alarms and `slice_hits` hold their values until `clr` is high on an edge. That edge zeroes them, and `clr` wins over any event that would set a bit on the same edge.
- R9: After reset, all five alarm bits and `slice_hits` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_out | input | DATA_W | Primary core output bus |
| shd_out | input | DATA_W | Shadow core output bus (two cycles late) |
| slice_map | input | DATA_W*6 | Slice ID of each compared bit, 6 bits per bit |
| cmp_disabled | input | 1 | Selects alarm bit 1 instead of bit 0 for divergence |
| inj_en | input | 1 | Enables fault injection into the main comparator |
| inj_slice | input | 6 | Slice whose main-comparator result is inverted |
| clr | input | 1 | Synchronous clear of alarms and slice mask |
| alarm | output | 5 | Sticky alarms; bit k is alarm k |
| slice_hits | output | 64 | Sticky mask of mismatching slice IDs |

## Verification
The assertions take for granted several things about the inputs:
- Every `slice_map` entry is below NUM_SLICES.
- `slice_map` is constant while the block runs.
- Inputs change only between clock edges.
- The shadow bus follows the primary bus with the two-cycle lag except when a fault is meant.

The delay-line property also waits for two cycles of history after reset. The bench keeps to these assumptions in the following ways:
- It drives all inputs on the falling edge.
- It assigns bit i to slice i mod 16.
- It holds `clr` for three cycles whenever the primary value jumps, so the delay line refills before anything can be recorded.
- It applies faults as single-cycle XOR patterns or single-cycle injections.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int SID_W      = 6;
  localparam int MAX_SLICES = 64;
  localparam int NUM_ALARMS = 5;

  typedef logic [MAX_SLICES-1:0] smask_t;

  typedef enum logic {DG_IDLE, DG_RUN} dstate_t;

  // one-hot slice mask for a slice ID
  function automatic smask_t sid_onehot(input logic [SID_W-1:0] id);
    return smask_t'(1) << id;
  endfunction

  // index of the divergence alarm selected by disabled mode
  function automatic int unsigned div_alarm_idx(input logic disabled);
    return disabled ? 1 : 0;
  endfunction
endpackage

// File: rtl/lsc_delay.sv
module lsc_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/lsc_slice_cmp.sv
module lsc_slice_cmp
  import lsc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic [W*SID_W-1:0] map,
  output smask_t             vec
);
  logic [W-1:0] diff;
  assign diff = a ^ b;

  always_comb begin
    vec = '0;
    for (int i = 0; i < W; i++) begin
      if (diff[i]) vec[map[i*SID_W +: SID_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/lsc_diag.sv
module lsc_diag
  import lsc_pkg::*;
#(
  parameter int W          = 32,
  parameter int NUM_SLICES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [W-1:0]       cap_a,
  input  logic [W-1:0]       cap_b,
  input  logic [W*SID_W-1:0] map,
  output logic               busy,
  output logic               done,
  output logic               hit
);
  localparam logic [SID_W-1:0] LAST = SID_W'(NUM_SLICES - 1);

  dstate_t          state;
  logic [SID_W-1:0] cnt;
  logic             found;
  logic [W-1:0]     snap_a, snap_b;
  smask_t           snap_vec;
  logic             cur;

  lsc_slice_cmp #(.W(W)) u_snap_cmp (
    .a  (snap_a),
    .b  (snap_b),
    .map(map),
    .vec(snap_vec)
  );

  assign cur  = snap_vec[cnt];
  assign busy = (state == DG_RUN);
  assign done = busy && (cnt == LAST);
  assign hit  = found | cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= DG_IDLE;
      cnt    <= '0;
      found  <= 1'b0;
      snap_a <= '0;
      snap_b <= '0;
    end else begin
      unique case (state)
        DG_IDLE: begin
          if (start) begin
            snap_a <= cap_a;
            snap_b <= cap_b;
            cnt    <= '0;
            found  <= 1'b0;
            state  <= DG_RUN;
          end
        end
        DG_RUN: begin
          found <= found | cur;
          if (cnt == LAST) state <= DG_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= DG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lsc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SLICES = 16,
  parameter int LAG        = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       pri_out,
  input  logic [DATA_W-1:0]       shd_out,
  input  logic [DATA_W*SID_W-1:0] slice_map,
  input  logic                    cmp_disabled,
  input  logic                    inj_en,
  input  logic [SID_W-1:0]        inj_slice,
  input  logic                    clr,
  output logic [NUM_ALARMS-1:0]   alarm,
  output logic [MAX_SLICES-1:0]   slice_hits
);
  // named internal events
  logic [DATA_W-1:0] pri_aligned;
  smask_t            main_raw, main_vec, sec_vec, inj_mask;
  logic              main_any, sec_any;
  logic              both_hit, disagree, accept_dis, record;
  logic              diag_busy, diag_done, diag_hit;

  lsc_delay #(.W(DATA_W), .DEPTH(LAG)) u_align (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pri_out),
    .q    (pri_aligned)
  );

  lsc_slice_cmp #(.W(DATA_W)) u_main (
    .a  (pri_aligned),
    .b  (shd_out),
    .map(slice_map),
    .vec(main_raw)
  );

  lsc_slice_cmp #(.W(DATA_W)) u_second (
    .a  (pri_aligned),
    .b  (shd_out),
    .map(slice_map),
    .vec(sec_vec)
  );

  assign inj_mask   = inj_en ? sid_onehot(inj_slice) : '0;
  assign main_vec   = main_raw ^ inj_mask;
  assign main_any   = |main_vec;
  assign sec_any    = |sec_vec;
  assign both_hit   = main_any && sec_any;
  assign disagree   = main_any ^ sec_any;
  assign accept_dis = disagree && !diag_busy;
  assign record     = both_hit || accept_dis;

  lsc_diag #(.W(DATA_W), .NUM_SLICES(NUM_SLICES)) u_diag (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept_dis),
    .cap_a(pri_aligned),
    .cap_b(shd_out),
    .map  (slice_map),
    .busy (diag_busy),
    .done (diag_done),
    .hit  (diag_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm      <= '0;
      slice_hits <= '0;
    end else if (clr) begin
      alarm      <= '0;
      slice_hits <= '0;
    end else begin
      if (record) begin
        alarm[div_alarm_idx(cmp_disabled)] <= 1'b1;
        slice_hits <= slice_hits | main_vec | sec_vec;
      end
      if (accept_dis) alarm[2] <= 1'b1;
      if (diag_done) begin
        if (diag_hit) alarm[4] <= 1'b1;
        else          alarm[3] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int DATA_W     = 32,
  parameter int NUM_SLICES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              cmp_disabled,
  input logic [DATA_W-1:0] pri_out,
  input logic [DATA_W-1:0] pri_aligned,
  input logic              main_any,
  input logic              sec_any,
  input logic              diag_busy,
  input logic              diag_done,
  input logic [4:0]        alarm,
  input logic [63:0]       slice_hits
);
  logic [1:0] age;
  logic [6:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age      <= '0;
      busy_len <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      busy_len <= diag_busy ? busy_len + 1'b1 : '0;
    end
  end

  p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (pri_aligned == $past(pri_out, 2)));

  p_div_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_any && sec_any && !clr && !cmp_disabled) |=> alarm[0]);

  p_div_dis_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_any && sec_any && !clr && cmp_disabled) |=> alarm[1]);

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_any != sec_any) && !diag_busy && !clr) |=> (alarm[2] && diag_busy));

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    diag_busy |-> (busy_len < 7'(NUM_SLICES)));

  p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_done && !clr) |=> (alarm[3] || alarm[4]));

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_any != sec_any) && diag_busy && !clr) |=> (slice_hits == $past(slice_hits)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((alarm & $past(alarm)) == $past(alarm)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (alarm == '0 && slice_hits == '0));
endmodule

bind lockstep_cmp lsc_checker #(.DATA_W(DATA_W), .NUM_SLICES(NUM_SLICES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .cmp_disabled(cmp_disabled),
  .pri_out     (pri_out),
  .pri_aligned (pri_aligned),
  .main_any    (main_any),
  .sec_any     (sec_any),
  .diag_busy   (diag_busy),
  .diag_done   (diag_done),
  .alarm       (alarm),
  .slice_hits  (slice_hits)
);

// File: tb/sim_lockstep_cmp.sv
`timescale 1ns/1ps
module sim_lockstep_cmp;
  localparam int DW = 32;
  localparam int NS = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [DW-1:0]  pri_out = '0, shd_out = '0;
  logic [DW*6-1:0] slice_map;
  logic           cmp_disabled = 1'b0, inj_en = 1'b0, clr = 1'b0;
  logic [5:0]     inj_slice = '0;
  logic [4:0]     alarm;
  logic [63:0]    slice_hits;

  int nvec = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  lockstep_cmp #(.DATA_W(DW), .NUM_SLICES(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .pri_out(pri_out), .shd_out(shd_out),
    .slice_map(slice_map), .cmp_disabled(cmp_disabled), .inj_en(inj_en),
    .inj_slice(inj_slice), .clr(clr), .alarm(alarm), .slice_hits(slice_hits)
  );

  // bit i belongs to slice i mod NS
  always_comb begin
    for (int i = 0; i < DW; i++) slice_map[i*6 +: 6] = 6'(i % NS);
  end

  typedef struct packed {
    logic [31:0] pri;
    logic [31:0] diff;
    logic        inj;
    logic [5:0]  sl;
    logic        dis;
    logic [4:0]  exp_al;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{32'hA5A5_0F0F, 32'h0000_0000, 1'b0, 6'd0, 1'b0, 5'b00000},
    '{32'h1234_5678, 32'h0000_0001, 1'b0, 6'd0, 1'b0, 5'b00001},
    '{32'hFFFF_0000, 32'h0002_0000, 1'b0, 6'd0, 1'b1, 5'b00010},
    '{32'h0000_0000, 32'h0000_0000, 1'b1, 6'd5, 1'b0, 5'b01101},
    '{32'hDEAD_BEEF, 32'h0000_0008, 1'b1, 6'd3, 1'b1, 5'b10110},
    '{32'h0F0F_F0F0, 32'h8004_0004, 1'b0, 6'd0, 1'b0, 5'b00001},
    '{32'h5555_AAAA, 32'h0000_0010, 1'b1, 6'd9, 1'b0, 5'b00001}
  };

  // slice mask from a bit difference plus an injected slice
  function automatic logic [63:0] exp_mask(input logic [31:0] diff, input logic inj,
                                           input logic [5:0] sl);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) if (diff[i]) m[i % NS] = 1'b1;
    if (inj) m[sl] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input logic [31:0] p);
    pri_out = p; shd_out = p; inj_en = 1'b0; clr = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R5 actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] h1, h2, p;
    repeat (3) @(negedge clk);
    chk("R9 reset alarms", 64'(alarm), 64'd0);
    chk("R9 reset mask", slice_hits, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'(alarm), 64'd0);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      cmp_disabled = TBL[v].dis;
      settle(TBL[v].pri);
      shd_out = TBL[v].pri ^ TBL[v].diff;
      inj_en = TBL[v].inj; inj_slice = TBL[v].sl;
      @(negedge clk);
      shd_out = TBL[v].pri; inj_en = 1'b0;
      repeat (NS + 3) @(negedge clk);
      chk($sformatf("R3/R4/R5 vector %0d alarms", v), 64'(alarm), 64'(TBL[v].exp_al));
      chk($sformatf("R7/R2 vector %0d slice mask", v), slice_hits,
          exp_mask(TBL[v].diff, TBL[v].inj, TBL[v].sl));
    end

    // R1: moving data with a two-cycle shadow lag gives no alarm
    cmp_disabled = 1'b0;
    settle(32'h0000_1000);
    h1 = 32'h0000_1000; h2 = 32'h0000_1000;
    for (int n = 0; n < 20; n++) begin
      p = 32'h0000_1000 + 32'(n * 7 + 1);
      shd_out = h2; h2 = h1; h1 = p; pri_out = p;
      @(negedge clk);
    end
    chk("R1 two-cycle lag accepted", 64'(alarm), 64'd0);
    // one-cycle lag is a divergence
    for (int n = 0; n < 4; n++) begin
      p = 32'h0000_2000 + 32'(n * 3 + 1);
      shd_out = h1; h2 = h1; h1 = p; pri_out = p;
      @(negedge clk);
    end
    chk("R1 one-cycle lag flagged", 64'(alarm[0]), 64'd1);

    // R5 timing and R6 ignore during a pass
    settle(32'h0000_0000);
    inj_en = 1'b1; inj_slice = 6'd5;
    @(posedge clk); #1;
    chk("R4 alarm2 on starting edge", 64'(alarm[2]), 64'd1);
    chk("R5 no result at start", 64'(alarm[3]), 64'd0);
    @(negedge clk); inj_slice = 6'd7;
    @(negedge clk); inj_en = 1'b0;
    repeat (NS - 2) @(posedge clk); #1;
    chk("R5 no result one edge early", 64'(alarm[4:3]), 64'd0);
    @(posedge clk); #1;
    chk("R5 alarm3 exactly NUM_SLICES edges later", 64'(alarm[3]), 64'd1);
    chk("R5 alarm4 clear", 64'(alarm[4]), 64'd0);
    chk("R6 ignored disagreement leaves mask", slice_hits, 64'h20);

    // R8 sticky then clear
    repeat (5) @(negedge clk);
    chk("R8 alarms sticky", 64'(alarm), 64'b01101);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 clear alarms", 64'(alarm), 64'd0);
    chk("R8 clear mask", slice_hits, 64'd0);
    // clear wins over a same-edge mismatch
    clr = 1'b1; shd_out = pri_out ^ 32'h1;
    @(negedge clk);
    clr = 1'b0; shd_out = pri_out;
    chk("R8 clear beats mismatch", 64'(alarm), 64'd0);
    chk("R8 clear beats mask set", slice_hits, 64'd0);

    finish_run();
  end
endmodule